// File: doc/BRIEF.md
# Power-on strap capture and frequency-code select

This block owns the six shared pins of a clock generator that serve as configuration inputs just after power-up and as clock drivers afterwards. Once reset is released it keeps the pins turned around as inputs for a timed capture window measured in reference-clock cycles. On the last cycle of that window it latches five frequency-select straps and one strap that picks the super-I/O clock rate. On the same edge it turns all six pins into outputs. The latched values then hold until the next reset.

The active 5-bit frequency code comes from one of two sources. By default it is the latched strap code. When an override bit in a configuration register byte is set, the code is assembled from select bits that lie scattered across that byte. The block also classifies the active code into one of three spread-spectrum modes. Frequency synthesis itself is done elsewhere.

Top module: `strap_fsel`

## Requirements
- R1: While `rst_n` is low and `cfg_byte[3]` is 0, `pad_oe` is 0, `fsel_code` is 0, `sio_24m` is 0 and `spread_mode` is 0.
- R2: `pad_oe` stays 0 through the first WIN_CYCLES+1 rising edges of `clk_ref` after `rst_n` rises. It becomes all ones on edge WIN_CYCLES+2, which is two synchronizer stages plus WIN_CYCLES window cycles. All six bits change together.
- R3: Once `pad_oe` is set it stays set until `rst_n` is asserted again.
- R4: The straps are captured from `pad_in` on the edge where `pad_oe` rises. `pad_in[4:0]` gives the strap code, with bit i as code bit i. `pad_in[5]` gives the super-I/O strap. Values present before that edge have no effect.
- R5: After capture, changes on `pad_in` affect neither `fsel_code` (with `cfg_byte[3]` = 0) nor `sio_24m`.
- R6: `sio_24m` equals the captured `pad_in[5]`. A 1 means the super-I/O clock runs at 24 MHz and a 0 means it runs at 48 MHz.
- R7: With `cfg_byte[3]` = 0, `fsel_code` equals the captured strap code. Before capture this code is 0.
- R8: With `cfg_byte[3]` = 1, `fsel_code` = {`cfg_byte[2]`, `cfg_byte[7]`, `cfg_byte[6]`, `cfg_byte[5]`, `cfg_byte[4]`}, from MSB to LSB, in the same cycle and without any clock edge. `cfg_byte[1:0]` never affects any output.
- R9: `spread_mode` is 2'b01 (centre spread, ±0.45%) for codes 01100 through 01111.
- R10: `spread_mode` is 2'b10 (down spread, −0.6%) for codes 00001, 10011, 10101 and 11100 through 11111.
- R11: `spread_mode` is 2'b00 (no spread) for every other code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock that times the capture window |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pad_in | input | 6 | Shared pin levels: [4:0] frequency straps, [5] super-I/O strap |
| cfg_byte | input | 8 | Register byte: [3] override, [7:4] and [2] select bits |
| fsel_code | output | 5 | Active frequency code |
| spread_mode | output | 2 | 00 off, 01 centre ±0.45%, 10 down −0.6% |
| sio_24m | output | 1 | 1 selects 24 MHz super-I/O clock, 0 selects 48 MHz |
| pad_oe | output | 6 | Output enables for the shared pins, same bit order as pad_in |

## Verification
The close of the window and a write to the override bit can fall in the same cycle. On that edge the strap register loads while the code multiplexer is switching source. The bench changes `pad_in` between the second-to-last and the last window edge, so only a correct final-edge capture yields the expected code. It then flips the override bit with no clock edge in between and checks `fsel_code` and `spread_mode` both before and after the flip. A second reset with different strap values confirms that the capture and the hold restart cleanly.

// File: rtl/strap_fsel_pkg.sv
package strap_fsel_pkg;

  localparam int FS_W  = 5;
  localparam int PAD_N = FS_W + 1;

  typedef enum logic [1:0] {
    SSM_OFF    = 2'b00,
    SSM_CENTER = 2'b01,
    SSM_DOWN   = 2'b10
  } ssm_e;

  // Classify a frequency code into its spread-spectrum mode.
  function automatic ssm_e ssm_decode(input logic [FS_W-1:0] code);
    ssm_e m;
    m = SSM_OFF;
    if (code[4:2] == 3'b011) begin
      m = SSM_CENTER;
    end else if (code[4:2] == 3'b111 || code == 5'b00001 ||
                 code == 5'b10011 || code == 5'b10101) begin
      m = SSM_DOWN;
    end
    return m;
  endfunction

endpackage

// File: rtl/strap_rst_sync.sv
module strap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_fsel_pkg::*;
#(
  parameter int WIN_CYCLES = 28636
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PAD_N-1:0] pad_in,
  output logic             cap_done,
  output logic [FS_W-1:0]  strap_code,
  output logic             strap_sio
);

  localparam int CW = $clog2(WIN_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

  logic [CW-1:0]   cnt_q, cnt_d;
  logic            done_q, done_d;
  logic            cnt_en;
  logic            cap_en;
  logic [FS_W-1:0] code_q;
  logic            sio_q;

  // Window sequencing: count until the final value, then stop for good.
  always_comb begin
    cnt_en = !done_q;
    cap_en = cnt_en && (cnt_q == LAST);
    cnt_d  = cnt_q + CW'(1);
    done_d = cap_en ? 1'b1 : done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (cnt_en && !cap_en) begin
        cnt_q <= cnt_d;
      end
      done_q <= done_d;
    end
  end

  // Strap holding registers, loaded only on the final window count.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      sio_q  <= 1'b0;
    end else if (cap_en) begin
      code_q <= pad_in[FS_W-1:0];
      sio_q  <= pad_in[PAD_N-1];
    end
  end

  assign cap_done   = done_q;
  assign strap_code = code_q;
  assign strap_sio  = sio_q;

endmodule

// File: rtl/fsel_select.sv
module fsel_select
  import strap_fsel_pkg::*;
(
  input  logic [FS_W-1:0] strap_code,
  input  logic [7:0]      cfg_byte,
  output logic [FS_W-1:0] code,
  output ssm_e            ssm
);

  logic            ovr;
  logic [FS_W-1:0] reg_code;
  logic            unused_cfg_bits;

  // Register select bits are scattered: top bit sits below the override bit.
  always_comb begin
    ovr      = cfg_byte[3];
    reg_code = {cfg_byte[2], cfg_byte[7], cfg_byte[6], cfg_byte[5], cfg_byte[4]};
    code     = ovr ? reg_code : strap_code;
    ssm      = ssm_decode(code);
  end

  assign unused_cfg_bits = ^cfg_byte[1:0];

endmodule

// File: rtl/strap_fsel.sv
module strap_fsel
  import strap_fsel_pkg::*;
#(
  parameter int WIN_CYCLES  = 28636,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic [5:0] pad_in,
  input  logic [7:0] cfg_byte,
  output logic [4:0] fsel_code,
  output logic [1:0] spread_mode,
  output logic       sio_24m,
  output logic [5:0] pad_oe
);

  logic            rst_sync_n;
  logic            cap_done;
  logic [FS_W-1:0] strap_code;
  logic            strap_sio;
  ssm_e            ssm;

  strap_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk        (clk_ref),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  strap_capture #(.WIN_CYCLES(WIN_CYCLES)) i_capture (
    .clk        (clk_ref),
    .rst_n      (rst_sync_n),
    .pad_in     (pad_in),
    .cap_done   (cap_done),
    .strap_code (strap_code),
    .strap_sio  (strap_sio)
  );

  fsel_select i_select (
    .strap_code (strap_code),
    .cfg_byte   (cfg_byte),
    .code       (fsel_code),
    .ssm        (ssm)
  );

  // One enable per shared pin, all driven from the capture flag.
  for (genvar g = 0; g < PAD_N; g++) begin : g_oe
    assign pad_oe[g] = cap_done;
  end

  assign spread_mode = ssm;
  assign sio_24m     = strap_sio;

endmodule

// File: rtl/strap_fsel_chk.sv
module strap_fsel_chk #(
  parameter int WIN_CYCLES  = 28636,
  parameter int SYNC_STAGES = 2
) (
  input logic       clk_ref,
  input logic       rst_n,
  input logic [7:0] cfg_byte,
  input logic [4:0] fsel_code,
  input logic [1:0] spread_mode,
  input logic       sio_24m,
  input logic [5:0] pad_oe
);

  localparam logic [31:0] OE_EDGE = 32'(WIN_CYCLES + SYNC_STAGES);

  logic [31:0] edges_q;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      edges_q <= '0;
    end else if (edges_q != 32'hFFFF_FFFF) begin
      edges_q <= edges_q + 32'd1;
    end
  end

  // R2
  oe_early_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (pad_oe != 6'd0) |-> (edges_q >= OE_EDGE));

  // R2
  oe_on_time_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (edges_q == OE_EDGE) |-> (pad_oe == 6'h3F));

  // R2
  oe_group_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (pad_oe == 6'h00) || (pad_oe == 6'h3F));

  // R3
  oe_sticky_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    pad_oe[0] |=> pad_oe[0]);

  // R5
  strap_hold_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (pad_oe[0] && $past(pad_oe[0]) && !cfg_byte[3] && !$past(cfg_byte[3]))
      |-> $stable(fsel_code));

  // R6
  sio_hold_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (pad_oe[0] && $past(pad_oe[0])) |-> $stable(sio_24m));

  // R9
  spread_center_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (fsel_code[4:2] == 3'b011) |-> (spread_mode == 2'b01));

  // R10
  spread_down_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (fsel_code[4:2] == 3'b111) |-> (spread_mode == 2'b10));

endmodule

bind strap_fsel strap_fsel_chk #(
  .WIN_CYCLES  (WIN_CYCLES),
  .SYNC_STAGES (SYNC_STAGES)
) i_strap_fsel_chk (
  .clk_ref     (clk_ref),
  .rst_n       (rst_n),
  .cfg_byte    (cfg_byte),
  .fsel_code   (fsel_code),
  .spread_mode (spread_mode),
  .sio_24m     (sio_24m),
  .pad_oe      (pad_oe)
);

// File: tb/test_strap_fsel.sv
module test_strap_fsel;

  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 20;

  logic       clk_ref;
  logic       rst_n;
  logic [5:0] pad_in;
  logic [7:0] cfg_byte;
  logic [4:0] fsel_code;
  logic [1:0] spread_mode;
  logic       sio_24m;
  logic [5:0] pad_oe;

  int checks;
  int errors;

  strap_fsel #(.WIN_CYCLES(WIN)) i_strap_fsel (
    .clk_ref     (clk_ref),
    .rst_n       (rst_n),
    .pad_in      (pad_in),
    .cfg_byte    (cfg_byte),
    .fsel_code   (fsel_code),
    .spread_mode (spread_mode),
    .sio_24m     (sio_24m),
    .pad_oe      (pad_oe)
  );

  initial begin
    clk_ref = 1'b0;
    forever #(CLK_PERIOD/2) clk_ref = ~clk_ref;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Register byte with override set that should produce the given code.
  function automatic logic [7:0] mk_cfg(input logic [4:0] c);
    return {c[3:0], 1'b1, c[4], 2'b00};
  endfunction

  function automatic logic [1:0] exp_spread(input logic [4:0] c);
    case (c)
      5'b01100, 5'b01101, 5'b01110, 5'b01111: return 2'b01;
      5'b00001, 5'b10011, 5'b10101,
      5'b11100, 5'b11101, 5'b11110, 5'b11111: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  // Reset, window, capture: pre value held until after edge WIN+1, then final.
  task automatic t_capture(input logic [5:0] pre, input logic [5:0] fin);
    @(negedge clk_ref);
    rst_n    = 1'b0;
    pad_in   = pre;
    cfg_byte = 8'h00;
    repeat (3) @(negedge clk_ref);
    chk("R1 pad_oe", 32'(pad_oe), 32'h0);
    chk("R1 fsel_code", 32'(fsel_code), 32'h0);
    chk("R1 sio_24m", 32'(sio_24m), 32'h0);
    chk("R1 spread_mode", 32'(spread_mode), 32'h0);
    rst_n = 1'b1;
    for (int k = 1; k <= WIN + 2; k++) begin
      @(posedge clk_ref);
      #1;
      if (k == WIN + 1) begin
        chk("R2 pad_oe before window end", 32'(pad_oe), 32'h0);
        chk("R7 code zero before capture", 32'(fsel_code), 32'h0);
        pad_in = fin;
      end
    end
    chk("R2 pad_oe at window end", 32'(pad_oe), 32'h3F);
    chk("R4 captured code", 32'(fsel_code), 32'(fin[4:0]));
    chk("R6 captured sio strap", 32'(sio_24m), 32'(fin[5]));
    chk("R7 strap spread", 32'(spread_mode), 32'(exp_spread(fin[4:0])));
  endtask

  task automatic t_hold(input logic [5:0] fin);
    @(negedge clk_ref);
    pad_in = ~fin;
    repeat (6) @(negedge clk_ref);
    chk("R5 code held", 32'(fsel_code), 32'(fin[4:0]));
    chk("R5 sio held", 32'(sio_24m), 32'(fin[5]));
    chk("R3 pad_oe held", 32'(pad_oe), 32'h3F);
  endtask

  task automatic t_override(input logic [4:0] strap);
    logic [4:0] pats [4];
    pats[0] = 5'b10110;
    pats[1] = 5'b01001;
    pats[2] = 5'b10000;
    pats[3] = 5'b00111;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_ref);
      cfg_byte = mk_cfg(pats[i]);
      #1;
      chk("R8 override code", 32'(fsel_code), 32'(pats[i]));
      cfg_byte[3] = 1'b0;
      #1;
      chk("R7 override cleared", 32'(fsel_code), 32'(strap));
    end
  endtask

  task automatic t_reserved(input logic [4:0] strap);
    @(negedge clk_ref);
    cfg_byte = 8'h03;
    #1;
    chk("R8 low bits ignored, no override", 32'(fsel_code), 32'(strap));
    cfg_byte = mk_cfg(5'b11010) | 8'h03;
    #1;
    chk("R8 low bits ignored, override", 32'(fsel_code), 32'h1A);
    chk("R8 low bits no spread effect", 32'(spread_mode), 32'(exp_spread(5'b11010)));
    repeat (2) @(negedge clk_ref);
    chk("R8 low bits no pad effect", 32'(pad_oe), 32'h3F);
    cfg_byte = 8'h00;
  endtask

  task automatic t_spread_sweep();
    for (int c = 0; c < 32; c++) begin
      @(negedge clk_ref);
      cfg_byte = mk_cfg(5'(c));
      #1;
      case (exp_spread(5'(c)))
        2'b01:   chk("R9 centre spread", 32'(spread_mode), 32'h1);
        2'b10:   chk("R10 down spread", 32'(spread_mode), 32'h2);
        default: chk("R11 no spread", 32'(spread_mode), 32'h0);
      endcase
    end
    @(negedge clk_ref);
    cfg_byte = 8'h00;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    checks   = 0;
    errors   = 0;
    rst_n    = 1'b0;
    pad_in   = 6'h00;
    cfg_byte = 8'h00;
    repeat (2) @(negedge clk_ref);
    t_capture(6'h00, {1'b1, 5'b01101});
    t_hold({1'b1, 5'b01101});
    t_override(5'b01101);
    t_reserved(5'b01101);
    t_spread_sweep();
    t_capture(6'h3F, {1'b0, 5'b10011});
    t_hold({1'b0, 5'b10011});
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule